// File: doc/BRIEF.md
# Registered Command Buffer with Bypass

This block is the address and control front end of a registered memory module. It accepts the host's row/column address, bank select, the three active-low command strobes, clock enable, four active-low chip selects and eight data-mask lines. It fans the address, bank, strobes and clock enable out as identical copies toward each device group, and forwards a single copy of the chip selects and masks.

A mode input chooses the path. When the mode input is low, every output follows its input through logic only. When the mode input is high, every input is captured on the rising clock edge, so each command reaches the devices one cycle after the host issued it. The data lines do not pass through this block. A host controller therefore has to move read capture and write data launch one cycle later, and the block reports that shift. It gives a one-bit latency adjustment and the host-visible CAS latency, which is the device CAS latency plus that adjustment.

The mode input is a static strap and may change only while reset is asserted. The active-low asynchronous reset puts the registered path into a deselect state.

Top module: `cmdbuf_top`

## Requirements
- R1: With `reg_en_i` low, every group output and the chip-select and mask outputs equal the present inputs in the same cycle, and clock edges do not change them.
- R2: With `reg_en_i` at any level other than low, every output shows the input value sampled at the most recent rising clock edge. An input change made between edges does not appear at the outputs until the next edge.
- R3: All `GRP_N` group copies of address, bank, RAS/CAS/WE strobes and CKE carry identical values at all times.
- R4: Chip selects and data masks go through the same path, transparent or registered, as the group signals, with a single copy of each.
- R5: `latency_adj_o` is 1 in registered mode and 0 in transparent mode.
- R6: `host_cl_o` equals `dev_cl_i + latency_adj_o` (device CAS latency 2 gives 3 when registered and 2 when transparent).
- R7: While `rst_ni` is low in registered mode, the outputs hold the deselect state: chip selects all 1, RAS/CAS/WE 1, CKE 0, address and bank 0, data masks all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_en_i | input | 1 | Path select: low = transparent, otherwise registered |
| dev_cl_i | input | CL_W | Device CAS latency programmed in the devices |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| ba_i | input | BA_W | Bank select |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | CS_N | Chip selects, active low |
| dqm_i | input | DQM_N | Data masks |
| grp_addr_o | output | GRP_N x ADDR_W | Address copy per device group |
| grp_ba_o | output | GRP_N x BA_W | Bank copy per group |
| grp_ras_no | output | GRP_N | Row strobe per group |
| grp_cas_no | output | GRP_N | Column strobe per group |
| grp_we_no | output | GRP_N | Write enable per group |
| grp_cke_o | output | GRP_N | Clock enable per group |
| cs_no | output | CS_N | Buffered chip selects |
| dqm_o | output | DQM_N | Buffered data masks |
| latency_adj_o | output | 1 | Extra cycles to add to host data timing |
| host_cl_o | output | CL_W+1 | Host-visible CAS latency |

## Verification
In registered mode the bench drives pseudo-random command words, walking-one address patterns, and the all-zero and all-one words. Each output must lag its input by exactly one edge, which catches a missing stage or an extra one. Some of these words are inverted shortly after the capturing edge. This separates a true edge-triggered capture from a path that leaks through. In transparent mode the same kinds of patterns are checked within the same cycle and again after a clock edge with the inputs held, which catches a register left in the bypass path. Reset values are checked both before the first clock and on a reset applied again mid-run. These checks separate the deselect polarity of each strobe from that of CKE.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_REG  = 1'b1
  } path_mode_e;

  // Anything other than a clean low (including an undriven strap) selects the registered path.
  function automatic path_mode_e decode_mode(input logic strap);
    path_mode_e m;
    case (strap)
      1'b0:    m = MODE_PASS;
      default: m = MODE_REG;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cmdbuf_mode_dec.sv
module cmdbuf_mode_dec
  import cmdbuf_pkg::*;
#(
  parameter int CL_W = 3
) (
  input  logic            reg_en_i,
  input  logic [CL_W-1:0] dev_cl_i,
  output logic            bypass_o,
  output logic            lat_adj_o,
  output logic [CL_W:0]   host_cl_o
);
  path_mode_e mode;

  always_comb begin
    mode      = decode_mode(reg_en_i);
    bypass_o  = (mode == MODE_PASS);
    lat_adj_o = (mode == MODE_REG);
    host_cl_o = {1'b0, dev_cl_i} + {{CL_W{1'b0}}, lat_adj_o};
  end
endmodule

// File: rtl/cmdbuf_stage.sv
module cmdbuf_stage #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bypass_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= RST_VAL;
    else         q_r <= d_i;
  end

  assign q_o = bypass_i ? d_i : q_r;
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int CS_N   = 4,
  parameter int DQM_N  = 8,
  parameter int GRP_N  = 2,
  parameter int CL_W   = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_en_i,
  input  logic [CL_W-1:0]              dev_cl_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [BA_W-1:0]              ba_i,
  input  logic                         ras_ni,
  input  logic                         cas_ni,
  input  logic                         we_ni,
  input  logic                         cke_i,
  input  logic [CS_N-1:0]              cs_ni,
  input  logic [DQM_N-1:0]             dqm_i,
  output logic [GRP_N-1:0][ADDR_W-1:0] grp_addr_o,
  output logic [GRP_N-1:0][BA_W-1:0]   grp_ba_o,
  output logic [GRP_N-1:0]             grp_ras_no,
  output logic [GRP_N-1:0]             grp_cas_no,
  output logic [GRP_N-1:0]             grp_we_no,
  output logic [GRP_N-1:0]             grp_cke_o,
  output logic [CS_N-1:0]              cs_no,
  output logic [DQM_N-1:0]             dqm_o,
  output logic                         latency_adj_o,
  output logic [CL_W:0]                host_cl_o
);
  // group word: {cke, ras_n, cas_n, we_n, ba, addr}
  localparam int GRP_W = ADDR_W + BA_W + 4;
  localparam logic [GRP_W-1:0] GRP_RST = {1'b0, 3'b111, {(BA_W + ADDR_W){1'b0}}};
  // sideband word: {cs_n, dqm}
  localparam int SB_W = CS_N + DQM_N;
  localparam logic [SB_W-1:0] SB_RST = {SB_W{1'b1}};

  logic             bypass;
  logic [GRP_W-1:0] grp_in;
  logic [SB_W-1:0]  sb_in;
  logic [SB_W-1:0]  sb_out;

  cmdbuf_mode_dec #(.CL_W(CL_W)) u_mode (
    .reg_en_i  (reg_en_i),
    .dev_cl_i  (dev_cl_i),
    .bypass_o  (bypass),
    .lat_adj_o (latency_adj_o),
    .host_cl_o (host_cl_o)
  );

  assign grp_in = {cke_i, ras_ni, cas_ni, we_ni, ba_i, addr_i};
  assign sb_in  = {cs_ni, dqm_i};

  // One register per group: each copy drives its own load.
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic [GRP_W-1:0] grp_out;

    cmdbuf_stage #(.W(GRP_W), .RST_VAL(GRP_RST)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bypass_i (bypass),
      .d_i      (grp_in),
      .q_o      (grp_out)
    );

    assign grp_addr_o[g] = grp_out[ADDR_W-1:0];
    assign grp_ba_o[g]   = grp_out[ADDR_W +: BA_W];
    assign grp_we_no[g]  = grp_out[ADDR_W+BA_W];
    assign grp_cas_no[g] = grp_out[ADDR_W+BA_W+1];
    assign grp_ras_no[g] = grp_out[ADDR_W+BA_W+2];
    assign grp_cke_o[g]  = grp_out[ADDR_W+BA_W+3];
  end

  cmdbuf_stage #(.W(SB_W), .RST_VAL(SB_RST)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass),
    .d_i      (sb_in),
    .q_o      (sb_out)
  );

  assign cs_no = sb_out[SB_W-1:DQM_N];
  assign dqm_o = sb_out[DQM_N-1:0];
endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int CS_N   = 4,
  parameter int DQM_N  = 8,
  parameter int GRP_N  = 2,
  parameter int CL_W   = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         reg_en_i,
  input logic [CL_W-1:0]              dev_cl_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [BA_W-1:0]              ba_i,
  input logic                         ras_ni,
  input logic                         cas_ni,
  input logic                         we_ni,
  input logic                         cke_i,
  input logic [CS_N-1:0]              cs_ni,
  input logic [DQM_N-1:0]             dqm_i,
  input logic [GRP_N-1:0][ADDR_W-1:0] grp_addr_o,
  input logic [GRP_N-1:0][BA_W-1:0]   grp_ba_o,
  input logic [GRP_N-1:0]             grp_ras_no,
  input logic [GRP_N-1:0]             grp_cas_no,
  input logic [GRP_N-1:0]             grp_we_no,
  input logic [GRP_N-1:0]             grp_cke_o,
  input logic [CS_N-1:0]              cs_no,
  input logic [DQM_N-1:0]             dqm_o,
  input logic                         latency_adj_o,
  input logic [CL_W:0]                host_cl_o
);
  logic seen_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_edge <= 1'b0;
    else         seen_edge <= 1'b1;
  end

  p_pass_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latency_adj_o |-> (grp_addr_o == {GRP_N{addr_i}} && grp_cke_o == {GRP_N{cke_i}} &&
                        cs_no == cs_ni && dqm_o == dqm_i));

  p_reg_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_edge && latency_adj_o && $past(latency_adj_o)) |->
      (grp_addr_o == $past({GRP_N{addr_i}}) && grp_ras_no == $past({GRP_N{ras_ni}}) &&
       cs_no == $past(cs_ni) && dqm_o == $past(dqm_i)));

  p_copies_equal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_addr_o == {GRP_N{grp_addr_o[0]}} && grp_ba_o == {GRP_N{grp_ba_o[0]}} &&
     grp_cke_o == {GRP_N{grp_cke_o[0]}} && grp_we_no == {GRP_N{grp_we_no[0]}}));

  p_host_cl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cl_o == ({1'b0, dev_cl_i} + {{CL_W{1'b0}}, latency_adj_o}));

  p_adj_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latency_adj_o == (reg_en_i !== 1'b0));

  p_first_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_edge && latency_adj_o) |->
      (cs_no == {CS_N{1'b1}} && grp_ras_no == {GRP_N{1'b1}} && grp_cke_o == '0));
endmodule

bind cmdbuf_top cmdbuf_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .CS_N(CS_N), .DQM_N(DQM_N), .GRP_N(GRP_N), .CL_W(CL_W)
) u_chk (.*);

// File: tb/cmdbuf_top_tb.sv
module cmdbuf_top_tb;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int CS_N   = 4;
  localparam int DQM_N  = 8;
  localparam int GRP_N  = 2;
  localparam int CL_W   = 3;
  localparam int VW     = ADDR_W + BA_W + 4 + CS_N + DQM_N;
  localparam int SBW    = CS_N + DQM_N;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic reg_en_i = 1'b1;
  logic [CL_W-1:0] dev_cl_i = 3'd2;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [BA_W-1:0] ba_i = '0;
  logic ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b0;
  logic [CS_N-1:0] cs_ni = '1;
  logic [DQM_N-1:0] dqm_i = '0;
  logic [GRP_N-1:0][ADDR_W-1:0] grp_addr_o;
  logic [GRP_N-1:0][BA_W-1:0] grp_ba_o;
  logic [GRP_N-1:0] grp_ras_no, grp_cas_no, grp_we_no, grp_cke_o;
  logic [CS_N-1:0] cs_no;
  logic [DQM_N-1:0] dqm_o;
  logic latency_adj_o;
  logic [CL_W:0] host_cl_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [VW-1:0] exp_q[$];
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #10 clk = ~clk;

  cmdbuf_top #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CS_N(CS_N), .DQM_N(DQM_N),
               .GRP_N(GRP_N), .CL_W(CL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_en_i(reg_en_i), .dev_cl_i(dev_cl_i),
    .addr_i(addr_i), .ba_i(ba_i), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cke_i(cke_i), .cs_ni(cs_ni), .dqm_i(dqm_i), .grp_addr_o(grp_addr_o),
    .grp_ba_o(grp_ba_o), .grp_ras_no(grp_ras_no), .grp_cas_no(grp_cas_no),
    .grp_we_no(grp_we_no), .grp_cke_o(grp_cke_o), .cs_no(cs_no), .dqm_o(dqm_o),
    .latency_adj_o(latency_adj_o), .host_cl_o(host_cl_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [VW-1:0] v);
    {addr_i, ba_i, ras_ni, cas_ni, we_ni, cke_i, cs_ni, dqm_i} = v;
  endtask

  // Compare every output against an expected input word.
  task automatic compare(input string req, input logic [VW-1:0] e);
    for (int g = 0; g < GRP_N; g++) begin
      chk({req, " R3 group"},
          64'({grp_addr_o[g], grp_ba_o[g], grp_ras_no[g], grp_cas_no[g], grp_we_no[g], grp_cke_o[g]}),
          64'(e[VW-1:SBW]));
    end
    chk({req, " R4 cs/dqm"}, 64'({cs_no, dqm_o}), 64'(e[SBW-1:0]));
  endtask

  function automatic logic [VW-1:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr[VW-1:0];
  endfunction

  // Driver: registered-mode vector, optionally corrupted just after capture.
  task automatic drive_reg(input logic [VW-1:0] v, input bit glitch);
    @(negedge clk);
    apply(v);
    exp_q.push_back(v);
    if (glitch) begin
      @(posedge clk);
      #2 apply(~v);
    end
  endtask

  // Monitor: scoreboard pop after each capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_en && exp_q.size() > 0) compare("R2", exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [VW-1:0] RST_WORD = {{ADDR_W{1'b0}}, {BA_W{1'b0}}, 3'b111, 1'b0,
                                        {CS_N{1'b1}}, {DQM_N{1'b1}}};

  initial begin
    logic [VW-1:0] v;
    apply({VW{1'b1}});
    #1 rst_ni = 1'b0;
    #2;
    compare("R7 reset", RST_WORD);
    chk("R5 adj registered", 64'(latency_adj_o), 64'd1);
    chk("R6 host cl 2+1", 64'(host_cl_o), 64'd3);
    dev_cl_i = 3'd3;
    #1 chk("R6 host cl 3+1", 64'(host_cl_o), 64'd4);
    @(negedge clk);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    drive_reg('0, 1'b0);
    drive_reg('1, 1'b1);
    for (int i = 0; i < ADDR_W; i++) drive_reg(VW'(1) << (SBW + 4 + BA_W + i), 1'b0);
    for (int i = 0; i < 40; i++) begin
      v = next_rand();
      drive_reg(v, i[0]);
    end
    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;

    // Reset applied mid-run, then switch to transparent.
    apply(next_rand());
    rst_ni = 1'b0;
    #1 compare("R7 reset midrun", RST_WORD);
    reg_en_i = 1'b0;
    dev_cl_i = 3'd2;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R5 adj transparent", 64'(latency_adj_o), 64'd0);
    chk("R6 host cl 2+0", 64'(host_cl_o), 64'd2);
    for (int i = 0; i < 20; i++) begin
      v = (i == 0) ? '0 : (i == 1) ? '1 : next_rand();
      @(negedge clk);
      apply(v);
      #1 compare("R1 same cycle", v);
      @(posedge clk);
      #3 compare("R1 after edge", v);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule